// File: doc/BRIEF.md
# Window Watchdog Timer

This block is a down-counting supervisor for a large chip. Software must refresh it from time to time. While it runs, a seven-bit counter loses one count for every group of prescaled ticks. If the counter drops out of its upper half, the block raises a reset request. A second fault is a refresh made too soon: software writes the counter while the count is still above a programmable window value. In both cases the block raises a reset request.

Two sources can start the block. One is a hardware option input. The other is a software counter write with its enable bit set. Once the block is running, no software write can stop it. The enable is cleared only by the block's own fault or by the system reset. After each fault request, the block returns to its reset state, so the surrounding reset tree can take the system down cleanly.

Top module: `wwd_top`

## Requirements
- R1: After `rst_n` is released, the counter and window registers read all ones (0x7F), the enable is low and no reset request is raised.
- R2: A counter write loads bits 6:0 of the write data into the counter. When write-data bit 7 is 1, the write also sets the enable. When bit 7 is 0, the enable keeps its current value, so a running watchdog cannot be stopped by software.
- R3: A window write loads a 7-bit window value, and this can happen at any time.
- R4: While the block is enabled, the counter decrements once every `PRESC_DIV` tick pulses. A counter write restarts this tick grouping. While the block is disabled, the counter holds its value.
- R5: While the block is enabled, a decrement from 0x40 to 0x3F (bit 6 falling) raises the reset request.
- R6: While the block is enabled, a counter write made when the counter exceeds the window value raises the reset request. A write made when the counter is less than or equal to the window value is accepted without a fault.
- R7: A counter write whose bit 6 is 0 raises the reset request if the block is already enabled, or if the same write enables it.
- R8: The reset request is high for exactly one cycle. It goes high on the clock edge that ends the cycle of the faulting event. On that same edge, the counter and window return to 0x7F and the enable clears.
- R9: While the hardware option input is high, the enable is set on the next edge. The enable falls only together with a reset request or under `rst_n`.
- R10: When a counter write and a decrementing tick occur in the same cycle, the write wins: the counter takes the written value and the tick grouping restarts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| hw_en_i | input | 1 | Hardware option: forces the watchdog on |
| tick_i | input | 1 | One-cycle prescaled time-base pulse |
| cnt_wr_i | input | 1 | Counter write strobe |
| cnt_wdata_i | input | 8 | Bit 7: enable request; bits 6:0: new count |
| win_wr_i | input | 1 | Window write strobe |
| win_wdata_i | input | 7 | New window value |
| cnt_o | output | 7 | Current counter value |
| win_o | output | 7 | Current window value |
| en_o | output | 1 | Watchdog running |
| rst_req_o | output | 1 | One-cycle reset request |

## Verification
Every result is registered. A write, a window update, or the tick that completes a group therefore shows up on the ports after the first rising edge following the cycle in which the stimulus was driven. The bench drives inputs 2 ns after a rising edge and samples 2 ns after the next one. Any reset request pulse is added into a per-step count, which shows that exactly one pulse appeared in the cycle it was due and none after it. Timeout checks count the ticks per decrement. This puts the fault on the tick that completes the 64th group, not one tick earlier or later.

// File: rtl/wwd_pkg.sv
package wwd_pkg;

  // Independent fault causes, evaluated in the same cycle.
  typedef struct packed {
    logic early;    // refresh while counter above window
    logic low_msb;  // write leaves the top counter bit clear
    logic expired;  // top counter bit falls on a decrement
  } wwd_fault_t;

  function automatic logic any_fault(input wwd_fault_t f);
    return f.early | f.low_msb | f.expired;
  endfunction

endpackage

// File: rtl/wwd_prescaler.sv
module wwd_prescaler #(
  parameter int unsigned DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  input  logic clear_i,
  input  logic tick_i,
  output logic step_o
);
  localparam int unsigned PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] pcnt_q, pcnt_d;
  logic          at_last;

  assign at_last = (pcnt_q == LAST);
  assign step_o  = run_i & tick_i & at_last;

  always_comb begin
    pcnt_d = pcnt_q;
    if (!run_i || clear_i) begin
      pcnt_d = '0;
    end else if (tick_i) begin
      pcnt_d = at_last ? '0 : pcnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pcnt_q <= '0;
    else        pcnt_q <= pcnt_d;
  end

  // R4: the group counter never passes its last value
  a_r4_grp_range: assert property (@(posedge clk) disable iff (!rst_n)
    pcnt_q <= LAST);

endmodule

// File: rtl/wwd_fault_det.sv
module wwd_fault_det
  import wwd_pkg::*;
#(
  parameter int unsigned CNT_W = 7
) (
  input  logic             en_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] win_i,
  input  logic             wr_i,
  input  logic [CNT_W:0]   wdata_i,
  input  logic             step_i,
  output wwd_fault_t       fault_o
);
  localparam logic [CNT_W-1:0] EDGE_VAL = {1'b1, {(CNT_W-1){1'b0}}};

  logic arming;

  always_comb begin
    arming          = en_i | (wr_i & wdata_i[CNT_W]);
    fault_o.early   = wr_i & en_i & (cnt_i > win_i);
    fault_o.low_msb = wr_i & arming & ~wdata_i[CNT_W-1];
    fault_o.expired = en_i & ~wr_i & step_i & (cnt_i == EDGE_VAL);
  end

  // Causes are only raised while running or arming
  always_comb begin
    if (!arming) assert (!any_fault(fault_o));
  end

endmodule

// File: rtl/wwd_regs.sv
module wwd_regs #(
  parameter int unsigned CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hw_en_i,
  input  logic             fault_i,
  input  logic             step_i,
  input  logic             wr_i,
  input  logic [CNT_W:0]   wdata_i,
  input  logic             win_wr_i,
  input  logic [CNT_W-1:0] win_wdata_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] win_o,
  output logic             en_o,
  output logic             req_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d, win_q, win_d;
  logic             en_q, en_d, req_q, req_d;

  always_comb begin
    cnt_d = cnt_q;
    win_d = win_q;
    en_d  = en_q | hw_en_i;
    req_d = 1'b0;
    if (win_wr_i) win_d = win_wdata_i;
    if (wr_i) begin
      cnt_d = wdata_i[CNT_W-1:0];
      if (wdata_i[CNT_W]) en_d = 1'b1;
    end else if (step_i) begin
      cnt_d = cnt_q - 1'b1;
    end
    if (fault_i) begin
      cnt_d = '1;
      win_d = '1;
      en_d  = 1'b0;
      req_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '1;
      win_q <= '1;
      en_q  <= 1'b0;
      req_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      win_q <= win_d;
      en_q  <= en_d;
      req_q <= req_d;
    end
  end

  assign cnt_o = cnt_q;
  assign win_o = win_q;
  assign en_o  = en_q;
  assign req_o = req_q;

  a_r8_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    req_q |=> !req_q);

  a_r9_sticky_en: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(en_q) |-> req_q);

  a_r4_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && !wr_i) |=> (cnt_q == $past(cnt_q)));

  a_r4_no_step_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && !wr_i && !step_i) |=> $stable(cnt_q));

endmodule

// File: rtl/wwd_top.sv
module wwd_top
  import wwd_pkg::*;
#(
  parameter int unsigned CNT_W     = 7,
  parameter int unsigned PRESC_DIV = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hw_en_i,
  input  logic             tick_i,
  input  logic             cnt_wr_i,
  input  logic [CNT_W:0]   cnt_wdata_i,
  input  logic             win_wr_i,
  input  logic [CNT_W-1:0] win_wdata_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] win_o,
  output logic             en_o,
  output logic             rst_req_o
);
  localparam logic [CNT_W-1:0] EDGE_VAL = {1'b1, {(CNT_W-1){1'b0}}};

  logic       step_w;
  logic       fault_w;
  wwd_fault_t cause_w;

  wwd_prescaler #(.DIV(PRESC_DIV)) u_presc (
    .clk     (clk),
    .rst_n   (rst_n),
    .run_i   (en_o),
    .clear_i (cnt_wr_i | fault_w),
    .tick_i  (tick_i),
    .step_o  (step_w)
  );

  wwd_fault_det #(.CNT_W(CNT_W)) u_det (
    .en_i    (en_o),
    .cnt_i   (cnt_o),
    .win_i   (win_o),
    .wr_i    (cnt_wr_i),
    .wdata_i (cnt_wdata_i),
    .step_i  (step_w),
    .fault_o (cause_w)
  );

  assign fault_w = any_fault(cause_w);

  wwd_regs #(.CNT_W(CNT_W)) u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .hw_en_i     (hw_en_i),
    .fault_i     (fault_w),
    .step_i      (step_w),
    .wr_i        (cnt_wr_i),
    .wdata_i     (cnt_wdata_i),
    .win_wr_i    (win_wr_i),
    .win_wdata_i (win_wdata_i),
    .cnt_o       (cnt_o),
    .win_o       (win_o),
    .en_o        (en_o),
    .req_o       (rst_req_o)
  );

  a_r5_timeout: assert property (@(posedge clk) disable iff (!rst_n)
    (en_o && step_w && !cnt_wr_i && cnt_o == EDGE_VAL) |=> rst_req_o);

  a_r6_early: assert property (@(posedge clk) disable iff (!rst_n)
    (en_o && cnt_wr_i && cnt_o > win_o) |=> rst_req_o);

  a_r6_in_window: assert property (@(posedge clk) disable iff (!rst_n)
    (en_o && cnt_wr_i && cnt_o <= win_o && cnt_wdata_i[CNT_W-1])
      |=> (!rst_req_o && cnt_o == $past(cnt_wdata_i[CNT_W-1:0])));

  a_r7_low_msb: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_wr_i && (en_o || cnt_wdata_i[CNT_W]) && !cnt_wdata_i[CNT_W-1])
      |=> rst_req_o);

  a_r9_hw_option: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_en_i && !fault_w) |=> en_o);

endmodule

// File: tb/tb_wwd_top.sv
module tb_wwd_top;
  localparam int CNT_W = 7;
  localparam int DIV   = 4;

  logic clk, rst_n, hw_en, tick, cwr, wwr;
  logic [7:0] cwd;
  logic [6:0] wwd;
  logic [6:0] cnt_o, win_o;
  logic en_o, rst_req_o;

  int checks = 0, fails = 0, pulses = 0;
  bit done = 0;

  wwd_top #(.CNT_W(CNT_W), .PRESC_DIV(DIV)) dut (
    .clk(clk), .rst_n(rst_n), .hw_en_i(hw_en), .tick_i(tick),
    .cnt_wr_i(cwr), .cnt_wdata_i(cwd), .win_wr_i(wwr), .win_wdata_i(wwd),
    .cnt_o(cnt_o), .win_o(win_o), .en_o(en_o), .rst_req_o(rst_req_o));

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // op: 0 window write, 1 counter write, 2 n ticks, 3 counter write with tick
  typedef struct packed {
    logic [1:0] op;
    logic [7:0] data;
    logic [8:0] n;
    logic [3:0] req;
    logic       exp_rst;
    logic [6:0] exp_cnt;
    logic       exp_en;
    logic [6:0] exp_win;
  } vec_t;

  localparam int NV = 25;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 8'h50, 9'd1,   4'd3,  1'b0, 7'h7F, 1'b0, 7'h50}, // R3
    '{2'd2, 8'h00, 9'd8,   4'd4,  1'b0, 7'h7F, 1'b0, 7'h50}, // R4 idle
    '{2'd1, 8'hFF, 9'd1,   4'd2,  1'b0, 7'h7F, 1'b1, 7'h50}, // R2 enable
    '{2'd2, 8'h00, 9'd128, 4'd4,  1'b0, 7'h5F, 1'b1, 7'h50}, // R4 32 steps
    '{2'd1, 8'hFF, 9'd1,   4'd6,  1'b1, 7'h7F, 1'b0, 7'h7F}, // R6 early, R8
    '{2'd0, 8'h50, 9'd1,   4'd3,  1'b0, 7'h7F, 1'b0, 7'h50}, // R3
    '{2'd1, 8'hFF, 9'd1,   4'd2,  1'b0, 7'h7F, 1'b1, 7'h50}, // R2
    '{2'd2, 8'h00, 9'd192, 4'd4,  1'b0, 7'h4F, 1'b1, 7'h50}, // R4
    '{2'd1, 8'hFF, 9'd1,   4'd6,  1'b0, 7'h7F, 1'b1, 7'h50}, // R6 in window
    '{2'd1, 8'hBF, 9'd1,   4'd7,  1'b1, 7'h7F, 1'b0, 7'h7F}, // R7
    '{2'd1, 8'hC0, 9'd1,   4'd2,  1'b0, 7'h40, 1'b1, 7'h7F}, // R2
    '{2'd2, 8'h00, 9'd3,   4'd4,  1'b0, 7'h40, 1'b1, 7'h7F}, // R4 partial group
    '{2'd2, 8'h00, 9'd1,   4'd5,  1'b1, 7'h7F, 1'b0, 7'h7F}, // R5
    '{2'd0, 8'h60, 9'd1,   4'd3,  1'b0, 7'h7F, 1'b0, 7'h60}, // R3
    '{2'd1, 8'hE0, 9'd1,   4'd2,  1'b0, 7'h60, 1'b1, 7'h60}, // R2
    '{2'd1, 8'hFF, 9'd1,   4'd6,  1'b0, 7'h7F, 1'b1, 7'h60}, // R6 equal
    '{2'd0, 8'h7F, 9'd1,   4'd3,  1'b0, 7'h7F, 1'b1, 7'h7F}, // R3
    '{2'd1, 8'h7F, 9'd1,   4'd2,  1'b0, 7'h7F, 1'b1, 7'h7F}, // R2 no disable
    '{2'd2, 8'h00, 9'd2,   4'd4,  1'b0, 7'h7F, 1'b1, 7'h7F}, // R4
    '{2'd3, 8'hF0, 9'd1,   4'd10, 1'b0, 7'h70, 1'b1, 7'h7F}, // R10 write wins
    '{2'd2, 8'h00, 9'd3,   4'd10, 1'b0, 7'h70, 1'b1, 7'h7F}, // R10 group restarted
    '{2'd2, 8'h00, 9'd1,   4'd10, 1'b0, 7'h6F, 1'b1, 7'h7F}, // R10
    '{2'd1, 8'h3F, 9'd1,   4'd7,  1'b1, 7'h7F, 1'b0, 7'h7F}, // R7 running
    '{2'd1, 8'h80, 9'd1,   4'd7,  1'b1, 7'h7F, 1'b0, 7'h7F}, // R7 arming
    '{2'd1, 8'h45, 9'd1,   4'd2,  1'b0, 7'h45, 1'b0, 7'h7F}  // R2 load only
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input logic w, input logic [7:0] d, input logic ww,
                     input logic [6:0] wd, input logic t);
    cwr = w; cwd = d; wwr = ww; wwd = wd; tick = t;
    @(posedge clk);
    #2;
    if (rst_req_o) pulses++;
    cwr = 1'b0; wwr = 1'b0; tick = 1'b0;
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; hw_en = 1'b0; tick = 1'b0; cwr = 1'b0; wwr = 1'b0;
    cwd = '0; wwd = '0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    @(posedge clk); #2;
    // R1 reset state
    chk(cnt_o == 7'h7F, "R1 cnt", cnt_o, 7'h7F);
    chk(win_o == 7'h7F, "R1 win", win_o, 7'h7F);
    chk(en_o == 1'b0 && rst_req_o == 1'b0, "R1 en/req", {en_o, rst_req_o}, 0);

    for (int i = 0; i < NV; i++) begin
      pulses = 0;
      case (VECS[i].op)
        2'd0: cyc(1'b0, 8'h00, 1'b1, VECS[i].data[6:0], 1'b0);
        2'd1: cyc(1'b1, VECS[i].data, 1'b0, 7'h00, 1'b0);
        2'd3: cyc(1'b1, VECS[i].data, 1'b0, 7'h00, 1'b1);
        default: for (int k = 0; k < int'(VECS[i].n); k++) cyc(1'b0, 8'h00, 1'b0, 7'h00, 1'b1);
      endcase
      chk(pulses == int'(VECS[i].exp_rst), $sformatf("R%0d vec%0d req", VECS[i].req, i),
          pulses, VECS[i].exp_rst);
      chk(cnt_o == VECS[i].exp_cnt, $sformatf("R%0d vec%0d cnt", VECS[i].req, i),
          cnt_o, VECS[i].exp_cnt);
      chk(en_o == VECS[i].exp_en, $sformatf("R%0d vec%0d en", VECS[i].req, i),
          en_o, VECS[i].exp_en);
      chk(win_o == VECS[i].exp_win, $sformatf("R%0d vec%0d win", VECS[i].req, i),
          win_o, VECS[i].exp_win);
      // R8: no pulse in the cycle after a step
      pulses = 0;
      cyc(1'b0, 8'h00, 1'b0, 7'h00, 1'b0);
      chk(pulses == 0, $sformatf("R8 vec%0d trailing", i), pulses, 0);
    end

    // R9 hardware option, full timeout from top (R5)
    rst_n = 1'b0; @(posedge clk); #2 rst_n = 1'b1;
    hw_en = 1'b1;
    cyc(1'b0, 8'h00, 1'b0, 7'h00, 1'b0);
    chk(en_o == 1'b1, "R9 hw enable", en_o, 1);
    pulses = 0;
    for (int k = 0; k < 63 * DIV; k++) cyc(1'b0, 8'h00, 1'b0, 7'h00, 1'b1);
    chk(cnt_o == 7'h40 && pulses == 0, "R5 at edge no req", {pulses, cnt_o}, 7'h40);
    for (int k = 0; k < DIV - 1; k++) cyc(1'b0, 8'h00, 1'b0, 7'h00, 1'b1);
    chk(pulses == 0, "R5 not early", pulses, 0);
    cyc(1'b0, 8'h00, 1'b0, 7'h00, 1'b1);
    chk(rst_req_o == 1'b1 && en_o == 1'b0, "R8 pulse clears en", {rst_req_o, en_o}, 2);
    chk(cnt_o == 7'h7F, "R8 cnt restored", cnt_o, 7'h7F);
    cyc(1'b0, 8'h00, 1'b0, 7'h00, 1'b0);
    chk(rst_req_o == 1'b0 && en_o == 1'b1, "R9 re-enabled by option", {rst_req_o, en_o}, 1);
    hw_en = 1'b0;
    cyc(1'b1, 8'h7F, 1'b0, 7'h00, 1'b0);
    chk(en_o == 1'b1, "R9 software cannot disable", en_o, 1);
    cyc(1'b0, 8'h00, 1'b1, 7'h22, 1'b0);
    rst_n = 1'b0; #2;
    chk(en_o == 1'b0 && win_o == 7'h7F, "R1 async reset", {en_o, win_o}, 7'h7F);
    @(posedge clk); #2 rst_n = 1'b1;
    cyc(1'b0, 8'h00, 1'b0, 7'h00, 1'b0);
    chk(en_o == 1'b0 && cnt_o == 7'h7F, "R1 after release", {en_o, cnt_o}, 7'h7F);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule